// File: doc/BRIEF.md
# Call Depth Counter Unit

This block keeps a 32-bit processor status word in a register and manages a 7-bit call-depth field in its low bits. The field holds a counter of variable width: a run of ones at the top of the field, read from bit 6 downward, sets how many low bits count. The value with all seven bits set turns depth counting off. Bit 7 of the word is the count-enable flag.

A call sequencer raises `incReq` when a call is made and `decReq` when a return is made. The block adds to or subtracts from the word, or holds it and raises a one-cycle `overflow` or `underflow` pulse that a trap unit can pick up. A context restore, or any other full rewrite, goes through `loadEn`/`loadWord`. The trap dispatch and the meaning of the other status bits are handled by other blocks.

Top module: `cdc_unit`

## Requirements
- R1: With `rstN` low, `statusWord` is 0 and both flags are 0. This holds also when reset is applied in the middle of a run.
- R2: `loadEn` high writes `loadWord` into `statusWord` at the next edge, with both flags 0. Any `incReq`/`decReq` in that cycle is ignored.
- R3: Take an increment with bit 7 set and field not 0x7F. If the incremented count bits are not zero, the whole word becomes word+1 and `overflow` stays 0. Bits 31..8 do not change.
- R4: Take an increment with bit 7 set and field not 0x7F. If the count bits of word+1, masked by that new value's mask, are zero, the word keeps its old value and `overflow` is 1 for that cycle.
- R5: Take a decrement with bit 7 set and field not 0x7F. If the masked count bits are not zero, the word becomes word-1 and `underflow` stays 0.
- R6: Take a decrement with bit 7 set and field not 0x7F. If the masked count bits are already zero, the word is unchanged and `underflow` is 1 for that cycle.
- R7: When field bits 6..0 equal 0x7F, an increment or a decrement leaves the word unchanged and raises no flag.
- R8: With bit 7 clear, an increment leaves bits 6..0 alone and sets bit 7. A decrement changes nothing. Neither raises a flag.
- R9: `incReq` and `decReq` high in the same cycle are both ignored: the word does not change and no flag is raised.
- R10: Let L be the number of consecutive ones in the field counted from bit 6 downward. The count mask is (1<<(7-L))-1. Examples: field 0x7D gives a 2-bit mask, 0x63 gives a 5-bit mask, and 0x40 gives a 6-bit mask.
- R11: `overflow` and `underflow` are single-cycle pulses, registered together with the word. They are never high at the same time, and they are 0 in any cycle without a counting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| incReq | input | 1 | Call: increment request |
| decReq | input | 1 | Return: decrement request |
| loadEn | input | 1 | Write the whole status word |
| loadWord | input | 32 | Value written when `loadEn` is high |
| statusWord | output | 32 | Registered status word |
| overflow | output | 1 | Depth overflow pulse |
| underflow | output | 1 | Depth underflow pulse |

## Verification
The word is the block's only state, and it sits directly on `statusWord`. A wrong mask width or a wrong count step therefore shows up on the port one edge after the request. The same is true of a missed revert. An error in the mask shows only at the boundary of a counter width. For that reason the stimulus loads fields with prefixes of several lengths and steps across each overflow and underflow edge, so a fault shows up within two cycles of the load.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // take the external word
    logic tryInc;   // counted increment
    logic tryDec;   // counted decrement
    logic forceEn;  // set the enable flag (any lone increment)
  } cdcStrobe_t;
endpackage

// File: rtl/cdc_ctrl.sv
module cdc_ctrl
  import cdc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int FIELD_W = 7,
  parameter int EN_BIT  = 7
) (
  input  logic              incReq,
  input  logic              decReq,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] curWord,
  output cdcStrobe_t        strobe
);
  localparam logic [FIELD_W-1:0] SAT_CODE = '1;

  logic loneInc, loneDec, countable;

  always_comb begin
    // both requests together form an illegal pair: drop both
    loneInc   = incReq && !decReq && !loadEn;
    loneDec   = decReq && !incReq && !loadEn;
    countable = curWord[EN_BIT] && (curWord[FIELD_W-1:0] != SAT_CODE);
    strobe.load    = loadEn;
    strobe.tryInc  = loneInc && countable;
    strobe.tryDec  = loneDec && countable;
    strobe.forceEn = loneInc;
  end

  always_comb begin
    assert_strobe_excl_R9: assert ($countones({strobe.load, strobe.tryInc, strobe.tryDec}) <= 1);
  end
endmodule

// File: rtl/cdc_path.sv
module cdc_path
  import cdc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int FIELD_W = 7,
  parameter int EN_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  cdcStrobe_t        strobe,
  input  logic [WORD_W-1:0] loadWord,
  output logic [WORD_W-1:0] wordQ,
  output logic              ovfQ,
  output logic              unfQ
);
  localparam logic [FIELD_W-1:0] SAT_CODE = '1;

  // mask covers the bits below the leading-ones prefix, including the first zero
  function automatic logic [FIELD_W-1:0] countMask(input logic [FIELD_W-1:0] f);
    logic inPrefix;
    logic [FIELD_W-1:0] m;
    inPrefix = 1'b1;
    m = '0;
    for (int i = FIELD_W - 1; i >= 0; i--) begin
      if (!(inPrefix && f[i])) begin
        inPrefix = 1'b0;
        m[i] = 1'b1;
      end
    end
    return m;
  endfunction

  logic [WORD_W-1:0] incWord, decWord, nextWord;
  logic incWrap, decEmpty, nextOvf, nextUnf;

  always_comb begin
    incWord  = wordQ + 1'b1;
    decWord  = wordQ - 1'b1;
    incWrap  = (incWord[FIELD_W-1:0] & countMask(incWord[FIELD_W-1:0])) == '0;
    decEmpty = (wordQ[FIELD_W-1:0] & countMask(wordQ[FIELD_W-1:0])) == '0;
    nextWord = wordQ;
    nextOvf  = 1'b0;
    nextUnf  = 1'b0;
    if (strobe.load) begin
      nextWord = loadWord;
    end else if (strobe.tryInc) begin
      nextOvf = incWrap;
      if (!incWrap) nextWord = incWord;
    end else if (strobe.tryDec) begin
      nextUnf = decEmpty;
      if (!decEmpty) nextWord = decWord;
    end
    if (strobe.forceEn) nextWord[EN_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      ovfQ  <= 1'b0;
      unfQ  <= 1'b0;
    end else begin
      wordQ <= nextWord;
      ovfQ  <= nextOvf;
      unfQ  <= nextUnf;
    end
  end

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfQ && unfQ));
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.forceEn) |=> !ovfQ);
  assert_ovf_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tryInc |=> (ovfQ -> (wordQ == $past(wordQ))));
  assert_unf_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tryDec |=> (unfQ -> (wordQ == $past(wordQ))));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (wordQ == $past(loadWord)) && !ovfQ && !unfQ);
  assert_sat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && wordQ[EN_BIT] && wordQ[FIELD_W-1:0] == SAT_CODE) |=> $stable(wordQ) && !ovfQ && !unfQ);
  assert_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(wordQ[WORD_W-1:EN_BIT+1]));
endmodule

// File: rtl/cdc_unit.sv
module cdc_unit
  import cdc_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int FIELD_W = 7,
  parameter int EN_BIT  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              incReq,
  input  logic              decReq,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] loadWord,
  output logic [WORD_W-1:0] statusWord,
  output logic              overflow,
  output logic              underflow
);
  cdcStrobe_t strobe;

  cdc_ctrl #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .EN_BIT(EN_BIT)) uCtrl (
    .incReq(incReq), .decReq(decReq), .loadEn(loadEn),
    .curWord(statusWord), .strobe(strobe)
  );

  cdc_path #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .EN_BIT(EN_BIT)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadWord(loadWord),
    .wordQ(statusWord), .ovfQ(overflow), .unfQ(underflow)
  );

  assert_both_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (incReq && decReq && !loadEn) |=> $stable(statusWord) && !overflow && !underflow);
  assert_dec_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (decReq && !incReq && !loadEn && !statusWord[EN_BIT]) |=> $stable(statusWord) && !underflow);
endmodule

// File: tb/tb_cdc_unit.sv
module tb_cdc_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        incReq = 1'b0, decReq = 1'b0, loadEn = 1'b0;
  logic [31:0] loadWord = '0;
  logic [31:0] statusWord;
  logic        overflow, underflow;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdc_unit dut (.*);

  typedef struct packed {
    logic        ld;
    logic [31:0] lw;
    logic        inc;
    logic        dec;
    logic [31:0] ew;
    logic        eo;
    logic        eu;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h00000080, 1'b0, 1'b0, 32'h00000080, 1'b0, 1'b0, 8'd2},  // R2
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h00000081, 1'b0, 1'b0, 8'd3},  // R3
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00000080, 1'b0, 1'b0, 8'd5},  // R5
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00000080, 1'b0, 1'b1, 8'd6},  // R6
    '{1'b1, 32'h000000BE, 1'b0, 1'b0, 32'h000000BE, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h000000BF, 1'b0, 1'b0, 8'd3},
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h000000BF, 1'b1, 1'b0, 8'd4},  // R4
    '{1'b1, 32'h800000FD, 1'b0, 1'b0, 32'h800000FD, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h800000FD, 1'b1, 1'b0, 8'd10}, // R10 2-bit mask
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h800000FC, 1'b0, 1'b0, 8'd5},
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h800000FC, 1'b0, 1'b1, 8'd10},
    '{1'b1, 32'h800000E3, 1'b1, 1'b0, 32'h800000E3, 1'b0, 1'b0, 8'd2},  // load wins
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h800000E4, 1'b0, 1'b0, 8'd10}, // 5-bit mask
    '{1'b1, 32'h000000FE, 1'b0, 1'b0, 32'h000000FE, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h000000FE, 1'b0, 1'b1, 8'd6},
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h000000FE, 1'b1, 1'b0, 8'd4},
    '{1'b1, 32'h123400FF, 1'b0, 1'b0, 32'h123400FF, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h123400FF, 1'b0, 1'b0, 8'd7},  // R7
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h123400FF, 1'b0, 1'b0, 8'd7},
    '{1'b1, 32'h00000005, 1'b0, 1'b0, 32'h00000005, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h00000005, 1'b0, 1'b0, 8'd8},  // R8
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h00000085, 1'b0, 1'b0, 8'd8},
    '{1'b0, 32'h0,        1'b1, 1'b0, 32'h00000086, 1'b0, 1'b0, 8'd3},
    '{1'b0, 32'h0,        1'b1, 1'b1, 32'h00000086, 1'b0, 1'b0, 8'd9},  // R9
    '{1'b0, 32'h0,        1'b0, 1'b0, 32'h00000086, 1'b0, 1'b0, 8'd11}, // R11
    '{1'b1, 32'h000000C0, 1'b0, 1'b0, 32'h000000C0, 1'b0, 1'b0, 8'd2},
    '{1'b0, 32'h0,        1'b0, 1'b1, 32'h000000C0, 1'b0, 1'b1, 8'd10}, // 6-bit mask
    '{1'b0, 32'h0,        1'b0, 1'b0, 32'h000000C0, 1'b0, 1'b0, 8'd11}
  };

  task automatic check(input int req, input logic [31:0] ew, input logic eo, input logic eu);
    checks++;
    if (statusWord !== ew || overflow !== eo || underflow !== eu) begin
      errors++;
      $display("FAIL R%0d word=%h ovf=%b unf=%b expected word=%h ovf=%b unf=%b",
               req, statusWord, overflow, underflow, ew, eo, eu);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 32'h0, 1'b0, 1'b0);  // R1 reset state
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      loadEn = VECS[i].ld; loadWord = VECS[i].lw;
      incReq = VECS[i].inc; decReq = VECS[i].dec;
      @(posedge clk); @(negedge clk);
      check(int'(VECS[i].req), VECS[i].ew, VECS[i].eo, VECS[i].eu);
    end
    // R11: overflow pulse lasts one cycle
    loadEn = 1'b1; loadWord = 32'h000000BF; incReq = 1'b0; decReq = 1'b0;
    @(posedge clk); @(negedge clk);
    loadEn = 1'b0; incReq = 1'b1;
    @(posedge clk); @(negedge clk);
    check(4, 32'h000000BF, 1'b1, 1'b0);
    incReq = 1'b0;
    @(posedge clk); @(negedge clk);
    check(11, 32'h000000BF, 1'b0, 1'b0);
    // R1: reset in mid-run clears the word
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1, 32'h0, 1'b0, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule